// File: doc/BRIEF.md
# Bit-Sliced Multi-Function ALU

This block is a 32-bit integer ALU. It is built as a chain of identical one-bit slices. Each slice may invert its A bit and its B bit, then forms an AND, an OR and a full-adder sum. A shared two-bit selector picks what the slice outputs. The carry ripples from slice to slice. The carry into the lowest slice equals the B-invert control, so inverting B also adds one and the chain computes A minus B.

Set-less-than works through a feedback bit into slice 0. That bit is the top slice's difference sign corrected by the signed overflow of the subtraction. NOR comes from inverting both operands and taking the AND path.

The arithmetic is purely combinational. An optional output register, on by default, gives a bench a clean sampling point. The 4-bit control word is `{invert_a, invert_b, select[1:0]}`. Bit positions and code values are part of the interface.

Top module: `slice_alu`

## Requirements
- R1: Code 4'b0000 gives `a & b` and code 4'b0001 gives `a | b`.
- R2: Code 4'b0010 gives `a + b` modulo 2^32, and `cout_o` is the carry out of bit 31.
- R3: Code 4'b0110 gives `a - b` modulo 2^32, and `cout_o` is the carry out of bit 31 of `a + ~b + 1`, which is 1 exactly when a >= b unsigned.
- R4: Code 4'b0111 gives 32'd1 when a < b as signed two's-complement numbers and 32'd0 otherwise. This holds even when a - b overflows.
- R5: Code 4'b1100 gives `~(a | b)`.
- R6: `ovf_o` is the signed overflow of the addition for code 4'b0010 and of the subtraction for code 4'b0110. For every other code both `ovf_o` and `cout_o` are 0.
- R7: For the six codes listed in R1 to R5, `zero_o` is 1 exactly when the result is all zeros.
- R8: Every other control code gives a result of zero, with `zero_o`, `ovf_o` and `cout_o` all 0.
- R9: With the output register enabled, outputs show the inputs applied before the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | Control word {invert_a, invert_b, select[1:0]} |
| res_o | output | 32 | Result |
| zero_o | output | 1 | Result-is-zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| cout_o | output | 1 | Carry out of the most significant slice |

## Verification
Every clock edge, the assertions compare the ripple chain's add, subtract and signed-compare results against native arithmetic. They also check that unused codes clear the result and all flags, and that overflow and carry stay low outside add and subtract. They check that the register passes the combinational value through with one cycle of delay. Only the bench's scenarios show the boundary operands: the most negative value, the most positive value, all ones and equal operands. Those operands drive set-less-than into overflowing subtractions, make the zero flag rise on equality, and exercise the carry flag at its limits.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  logic             inv_a, inv_b;
  logic [1:0]       sel;
  logic [WIDTH-1:0] pa, pb, sum, slice_y, y_c;
  logic [WIDTH:0]   carry;
  logic             ovf_raw, less0, valid, arith, z_c, v_c, c_c;

  assign inv_a = ctrl_i[3];
  assign inv_b = ctrl_i[2];
  assign sel   = ctrl_i[1:0];

  always_comb begin
    carry[0] = inv_b;
    for (int i = 0; i < WIDTH; i++) begin
      pa[i]      = a_i[i] ^ inv_a;
      pb[i]      = b_i[i] ^ inv_b;
      sum[i]     = pa[i] ^ pb[i] ^ carry[i];
      carry[i+1] = (pa[i] & pb[i]) | ((pa[i] | pb[i]) & carry[i]);
    end
    ovf_raw = carry[WIDTH] ^ carry[WIDTH-1];
    less0   = sum[WIDTH-1] ^ ovf_raw;
    for (int i = 0; i < WIDTH; i++) begin
      case (sel)
        2'b00:   slice_y[i] = pa[i] & pb[i];
        2'b01:   slice_y[i] = pa[i] | pb[i];
        2'b10:   slice_y[i] = sum[i];
        default: slice_y[i] = (i == 0) ? less0 : 1'b0;
      endcase
    end
  end

  assign valid = (ctrl_i == OP_AND) || (ctrl_i == OP_OR)  || (ctrl_i == OP_ADD) ||
                 (ctrl_i == OP_SUB) || (ctrl_i == OP_SLT) || (ctrl_i == OP_NOR);
  assign arith = (ctrl_i == OP_ADD) || (ctrl_i == OP_SUB);
  assign y_c   = valid ? slice_y : '0;
  assign z_c   = valid && (y_c == '0);
  assign v_c   = arith & ovf_raw;
  assign c_c   = arith & carry[WIDTH];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_o  <= '0;
          zero_o <= 1'b0;
          ovf_o  <= 1'b0;
          cout_o <= 1'b0;
        end else begin
          res_o  <= y_c;
          zero_o <= z_c;
          ovf_o  <= v_c;
          cout_o <= c_c;
        end
      end

      // R9
      reg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_o == $past(y_c)) && (ovf_o == $past(v_c)) && (cout_o == $past(c_c)));
    end else begin : g_comb
      assign res_o  = y_c;
      assign zero_o = z_c;
      assign ovf_o  = v_c;
      assign cout_o = c_c;
    end
  endgenerate

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == OP_ADD) |-> (y_c == WIDTH'(a_i + b_i)));

  // R3
  sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == OP_SUB) |-> (y_c == WIDTH'(a_i - b_i)) && (c_c == (a_i >= b_i)));

  // R4
  slt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == OP_SLT) |-> (y_c == WIDTH'($signed(a_i) < $signed(b_i))));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ctrl_i == OP_ADD) || (ctrl_i == OP_SUB)) |-> !v_c && !c_c);

  // R8
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (y_c == '0) && !z_c && !v_c && !c_c);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i == OP_SUB) |-> (z_c == (a_i == b_i)));
endmodule

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] y;
    logic        z, v, c;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  ctrl = '0;
  logic [31:0] res;
  logic        zero, ovf, cout;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;
  exp_t        q[$];

  always #2 clk = ~clk;

  slice_alu #(.WIDTH(32), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .res_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout));

  function automatic exp_t model(logic [3:0] op, logic [31:0] x, logic [31:0] w);
    exp_t e;
    logic [32:0] s;
    e = '0;
    e.op = op;
    case (op)
      4'b0000: e.y = x & w;
      4'b0001: e.y = x | w;
      4'b0010: begin
        s = {1'b0, x} + {1'b0, w};
        e.y = s[31:0]; e.c = s[32];
        e.v = (x[31] == w[31]) && (s[31] != x[31]);
      end
      4'b0110: begin
        e.y = x - w; e.c = (x >= w);
        e.v = (x[31] != w[31]) && (e.y[31] != x[31]);
      end
      4'b0111: e.y = {31'b0, ($signed(x) < $signed(w))};
      4'b1100: e.y = ~(x | w);
      default: e.y = '0;
    endcase
    if (op inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})
      e.z = (e.y == 32'd0);
    return e;
  endfunction

  function automatic string res_tag(logic [3:0] op);
    case (op)
      4'b0000, 4'b0001: return "R1";
      4'b0010: return "R2";
      4'b0110: return "R3";
      4'b0111: return "R4";
      4'b1100: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [31:0] x, logic [31:0] w);
    @(negedge clk);
    ctrl = op; a = x; b = w;
    q.push_back(model(op, x, w));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp({res_tag(e.op), " result"}, res, e.y);
        cmp("R7 zero", {31'b0, zero}, {31'b0, e.z});
        cmp("R6 ovf", {31'b0, ovf}, {31'b0, e.v});
        cmp((e.op == 4'b0110) ? "R3 cout" : "R2/R6 cout", {31'b0, cout}, {31'b0, e.c});
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] corners [5];
    logic [3:0]  ops [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'h8000_0000; corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'hFFFF_FFFF; corners[4] = 32'h0000_0001;
    ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
    ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;
    a = 32'hDEAD_BEEF; b = 32'h1234_5678; ctrl = 4'b0010;
    repeat (3) @(posedge clk);
    #1;
    cmp("R9 reset res", res, 32'd0);
    cmp("R9 reset flags", {29'b0, zero, ovf, cout}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 6; k++)
          drive(ops[k], corners[i], corners[j]);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom;
      for (int k = 0; k < 6; k++) drive(ops[k], r, r);
    end
    for (int n = 0; n < 200; n++) begin
      logic [31:0] x, w;
      x = $urandom; w = $urandom;
      for (int op = 0; op < 16; op++) drive(4'(op), x, w);
    end
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule